// File: doc/BRIEF.md
# Dual-Supply Supervisor Controller

This block is the digital half of a two-rail supply supervisor. Two analog comparators sit outside it. One reports that the main rail is below its trip point and the other reports that the secondary rail is below its own. The block also takes a watchdog kick from the system and a one-millisecond tick from a shared prescaler. From these it produces a system reset that is stretched by a selectable hold time, and a watchdog output that fires when the kicks stop.

A small volatile fault register records what went wrong. Its flags are active-low: they come up as zero, and the host arms them by writing all ones. A flag drops to zero when its fault is seen. After a reset the host reads the register at address 0xFF to learn the cause, then arms it again. All timing is counted in millisecond ticks, so the block's clock rate does not enter the time limits.

Top module: `dual_supply_supervisor`

## Requirements
- R1: While `rst_n` is low and just after it is released, `sup_rst` is 1, `wdog_out` is 0, and a read of 0xFF returns 0x00.
- R2: `sup_rst` stays 1 until the main rail has been good for the hold time chosen by `hold_sel`: 0 gives 50 ticks, 1 gives 200, 2 gives 400 and 3 gives 800. It falls on the clock edge that samples the last of those `ms_tick` pulses.
- R3: `main_low`=1 drives `sup_rst` to 1 in the same cycle. When the rail recovers, the full hold time is counted again from zero.
- R4: `wd_sel` picks the watchdog interval: 0 gives 25 ticks, 1 gives 200, 2 gives 1400, and 3 disables the watchdog. `wdog_out` rises on the edge that samples the interval's last tick with no kick in between. When the watchdog is disabled, `wdog_out` stays 0.
- R5: A one-cycle `wd_kick` clears `wdog_out` and restarts the interval from zero at the next edge. While `sup_rst` is 1 the watchdog does not count, and it starts from zero when `sup_rst` falls.
- R6: In the fault register, bit 0 flags the main rail, bit 1 the secondary rail and bit 2 the watchdog. A write at 0xFF loads bits 2..0 from `reg_wdata`.
- R7: A flag is forced to 0 at the edge after its condition is seen: `main_low`, `aux_low` or `wdog_out` high. A host write of ones in that same cycle leaves the flag at 0.
- R8: Without a host write, fault flags only move from 1 to 0. A flag stays 0 after its condition goes away.
- R9: Bits 7..3 always read 0 and writes to them are ignored. Writes to any address other than 0xFF change nothing.
- R10: A `reg_rd` pulse gives `reg_rvalid`=1 for exactly one cycle at the next edge. `reg_rdata` holds the register value from before that cycle's update when the address is 0xFF, and 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-up |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| main_low | input | 1 | Main rail below trip 1 |
| aux_low | input | 1 | Secondary rail below trip 2 |
| wd_kick | input | 1 | Watchdog restart pulse |
| hold_sel | input | 2 | Reset hold time select |
| wd_sel | input | 2 | Watchdog interval select |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle |
| sup_rst | output | 1 | System reset, active high |
| wdog_out | output | 1 | Watchdog expired, active high |

## Verification
`sup_rst` responds to `main_low` without delay. Its release comes at the edge that samples the Nth tick, so the bench drives N-1 ticks and checks that reset is still high, then drives one more tick and checks that it is low. `wdog_out` follows the same rule: one edge after its last tick, and one edge after a kick. Fault flags change one edge after their condition. Read data arrives one edge after `reg_rd`; a scoreboard queues the expected byte when the read is issued and compares it when `reg_rvalid` appears. All sampling happens on falling clock edges, after the inputs have settled.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  localparam logic [7:0] FLT_ADDR  = 8'hFF;
  localparam int         FLT_MAIN  = 0;
  localparam int         FLT_AUX   = 1;
  localparam int         FLT_WDOG  = 2;
  localparam int         FLT_BITS  = 3;
  localparam logic [7:0] FLT_MASK  = 8'h07;

  typedef enum logic [1:0] {
    WD_SHORT = 2'd0,
    WD_MID   = 2'd1,
    WD_LONG  = 2'd2,
    WD_OFF   = 2'd3
  } wd_sel_e;
endpackage

// File: rtl/fsup_tick_timer.sv
module fsup_tick_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = (cnt_q >= limit);
  assign cnt_en = clear | (tick & ~done);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)             cnt_d = '0;
    else if (tick && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fsup_fault_reg.sv
module fsup_fault_reg
  import fsup_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          addr,
  input  logic                wr,
  input  logic                rd,
  input  logic [7:0]          wdata,
  input  logic [FLT_BITS-1:0] evt,
  output logic [7:0]          rdata,
  output logic                rvalid
);
  logic [FLT_BITS-1:0] flt_q, flt_d;
  logic [7:0]          rdata_d;
  logic                wr_hit;

  assign wr_hit = wr & (addr == FLT_ADDR);

  always_comb begin
    flt_d = flt_q;
    if (wr_hit) flt_d = wdata[FLT_BITS-1:0];
    flt_d = flt_d & ~evt;
  end

  always_comb begin
    rdata_d = 8'h00;
    if (addr == FLT_ADDR) rdata_d = {{(8-FLT_BITS){1'b0}}, flt_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= '0;
    else        flt_q <= flt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= 8'h00;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rdata_d;
    end
  end

  p_flag_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flt_q & $past(evt)) == '0));
  p_only_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ((flt_q & ~$past(flt_q)) == '0));
  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ((rdata & ~FLT_MASK) == 8'h00));
  p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rvalid);
endmodule

// File: rtl/dual_supply_supervisor.sv
module dual_supply_supervisor
  import fsup_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int HOLD_0 = 50,
  parameter int HOLD_1 = 200,
  parameter int HOLD_2 = 400,
  parameter int HOLD_3 = 800,
  parameter int WD_0   = 25,
  parameter int WD_1   = 200,
  parameter int WD_2   = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       main_low,
  input  logic       aux_low,
  input  logic       wd_kick,
  input  logic [1:0] hold_sel,
  input  logic [1:0] wd_sel,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       reg_rvalid,
  output logic       sup_rst,
  output logic       wdog_out
);
  localparam logic [CNT_W-1:0] LIM_MAX = '1;

  logic [CNT_W-1:0]    hold_lim, wd_lim;
  logic                hold_done, wd_done, wd_en, wd_clr;
  logic [FLT_BITS-1:0] flt_evt;

  always_comb begin
    case (hold_sel)
      2'd0:    hold_lim = CNT_W'(HOLD_0);
      2'd1:    hold_lim = CNT_W'(HOLD_1);
      2'd2:    hold_lim = CNT_W'(HOLD_2);
      default: hold_lim = CNT_W'(HOLD_3);
    endcase
  end

  always_comb begin
    case (wd_sel_e'(wd_sel))
      WD_SHORT: wd_lim = CNT_W'(WD_0);
      WD_MID:   wd_lim = CNT_W'(WD_1);
      WD_LONG:  wd_lim = CNT_W'(WD_2);
      default:  wd_lim = LIM_MAX;
    endcase
  end

  fsup_tick_timer #(.CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(main_low), .tick(ms_tick),
    .limit(hold_lim), .done(hold_done)
  );

  assign sup_rst = main_low | ~hold_done;
  assign wd_en   = (wd_sel_e'(wd_sel) != WD_OFF);
  assign wd_clr  = wd_kick | sup_rst | ~wd_en;

  fsup_tick_timer #(.CNT_W(CNT_W)) u_wdog (
    .clk(clk), .rst_n(rst_n), .clear(wd_clr), .tick(ms_tick),
    .limit(wd_lim), .done(wd_done)
  );

  assign wdog_out = wd_done & wd_en;

  always_comb begin
    flt_evt           = '0;
    flt_evt[FLT_MAIN] = main_low;
    flt_evt[FLT_AUX]  = aux_low;
    flt_evt[FLT_WDOG] = wdog_out;
  end

  fsup_fault_reg u_flt (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .evt(flt_evt), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sup_rst) && $stable(hold_sel)) |-> ($past(ms_tick) && !$past(main_low)));
  p_low_holds_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(main_low) |-> $past(sup_rst));
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_kick |=> !wdog_out);
  p_no_wd_in_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rst |=> !wdog_out);
  p_wd_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_sel == 2'd3) |-> !wdog_out);
endmodule

// File: tb/tb_dual_supply_supervisor.sv
module tb_dual_supply_supervisor;
  logic       clk = 1'b0;
  logic       rst_n, ms_tick, main_low, aux_low, wd_kick;
  logic [1:0] hold_sel, wd_sel;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, reg_rvalid, sup_rst, wdog_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  dual_supply_supervisor dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .main_low(main_low),
    .aux_low(aux_low), .wd_kick(wd_kick), .hold_sel(hold_sel), .wd_sel(wd_sel),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .sup_rst(sup_rst),
    .wdog_out(wdog_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per read response
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected rvalid actual=%h expected=none", reg_rdata);
      end else begin
        check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ms_tick = 1'b1;
      @(negedge clk); ms_tick = 1'b0;
    end
    #1;
  endtask

  task automatic bus(input logic rd, input logic wr, input logic [7:0] a,
                     input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    @(negedge clk);
    reg_rd = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    bus(1'b1, 1'b0, a, 8'h00, exp, tag);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus(1'b0, 1'b1, a, d, 8'h00, "");
  endtask

  task automatic kick();
    @(negedge clk); wd_kick = 1'b1;
    @(negedge clk); wd_kick = 1'b0;
    #1;
  endtask

  task automatic hold_test(input logic [1:0] sel, input int n, input string tag);
    @(negedge clk); hold_sel = sel; main_low = 1'b1; #1;
    check({tag, " R3 immediate reset"}, {7'd0, sup_rst}, 8'd1);
    ticks(3);
    @(negedge clk); main_low = 1'b0;
    ticks(n - 1);
    check({tag, " held before last tick"}, {7'd0, sup_rst}, 8'd1);
    ticks(1);
    check({tag, " released after last tick"}, {7'd0, sup_rst}, 8'd0);
  endtask

  task automatic wd_test(input logic [1:0] sel, input int n, input string tag);
    @(negedge clk); wd_sel = sel;
    kick();
    ticks(n - 1);
    check({tag, " wd quiet before last tick"}, {7'd0, wdog_out}, 8'd0);
    ticks(1);
    check({tag, " wd fires"}, {7'd0, wdog_out}, 8'd1);
    kick();
    check({tag, " R5 kick clears"}, {7'd0, wdog_out}, 8'd0);
  endtask

  initial begin
    #1600000;
    failures++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; main_low = 1'b0; aux_low = 1'b0; wd_kick = 1'b0;
    hold_sel = 2'd0; wd_sel = 2'd3; reg_addr = 8'h00; reg_wdata = 8'h00;
    reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sup_rst in reset", {7'd0, sup_rst}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sup_rst after release", {7'd0, sup_rst}, 8'd1);
    check("R1 wdog_out after release", {7'd0, wdog_out}, 8'd0);
    rd_chk(8'hFF, 8'h00, "R1 fault reg zero");

    // R2 power-on hold, 50 ticks
    ticks(49);
    check("R2 hold 50 not yet", {7'd0, sup_rst}, 8'd1);
    ticks(1);
    check("R2 hold 50 done", {7'd0, sup_rst}, 8'd0);

    // R6 arm, R9 reserved
    wr_reg(8'hFF, 8'hFF);
    rd_chk(8'hFF, 8'h07, "R6 armed R9 reserved zero");
    wr_reg(8'h10, 8'h00);
    rd_chk(8'hFF, 8'h07, "R9 other address write ignored");
    rd_chk(8'h10, 8'h00, "R10 other address reads zero");

    // R4/R5 watchdog 25 with kick mid-way
    @(negedge clk); wd_sel = 2'd0;
    kick();
    ticks(20);
    kick();
    ticks(24);
    check("R5 kick restarted interval", {7'd0, wdog_out}, 8'd0);
    ticks(1);
    check("R4 wd 25 fires", {7'd0, wdog_out}, 8'd1);
    @(negedge clk);
    rd_chk(8'hFF, 8'h03, "R7 wd flag dropped");
    kick();
    check("R5 kick clears wdog_out", {7'd0, wdog_out}, 8'd0);

    // R4 disabled
    @(negedge clk); wd_sel = 2'd3;
    ticks(1500);
    check("R4 wd off stays quiet", {7'd0, wdog_out}, 8'd0);

    // R10 read and write same cycle returns old value
    bus(1'b1, 1'b1, 8'hFF, 8'hFF, 8'h03, "R10 read before write");
    rd_chk(8'hFF, 8'h07, "R6 rearmed");

    // R7 aux fault with write in same cycle
    @(negedge clk); aux_low = 1'b1;
    bus(1'b0, 1'b1, 8'hFF, 8'hFF, 8'h00, "");
    @(negedge clk); aux_low = 1'b0;
    rd_chk(8'hFF, 8'h05, "R7 aux flag beats write");
    ticks(5);
    rd_chk(8'hFF, 8'h05, "R8 aux flag stays low");
    wr_reg(8'hFF, 8'hF8);
    rd_chk(8'hFF, 8'h00, "R9 reserved write bits ignored");
    wr_reg(8'hFF, 8'hFF);

    // R3/R5 main-rail dip with watchdog suspended during reset
    @(negedge clk); wd_sel = 2'd1;
    kick();
    hold_test(2'd1, 200, "R2 hold 200");
    rd_chk(8'hFF, 8'h06, "R7 main flag dropped");
    ticks(199);
    check("R5 wd suspended in reset", {7'd0, wdog_out}, 8'd0);
    ticks(1);
    check("R5 wd 200 from release", {7'd0, wdog_out}, 8'd1);
    kick();

    hold_test(2'd2, 400, "R2 hold 400");
    hold_test(2'd3, 800, "R2 hold 800");
    wd_test(2'd2, 1400, "R4 wd 1400");
    wd_test(2'd0, 25, "R4 wd 25");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule